// File: doc/BRIEF.md
# Multi-Port GPIO Register Block

A memory-mapped general-purpose I/O controller that places three regular bidirectional ports (8, 24 and 13 pins wide) and one mixed port behind a single 32-bit register interface. The mixed port combines six bidirectional pins, an input-only group and a 24-pin output-only group. Every change to an output level, a pin direction or a mux selection goes through a write-one-to-set or write-one-to-clear register. Software can therefore change single pins without a read-modify-write sequence.

Pin inputs pass through a two-flop synchronizer before they appear in the input state registers. Output levels, direction (output enable) and mux state can be read back. The mixed port keeps some legacy layout quirks. Its bidirectional pins take their direction from high bits of the 13-pin port's direction registers, and their input bits sit at positions that are not contiguous. The register bus has a byte address, a write strobe and write data. Read data is combinational from the presented address.

Top module: `gpio_multiport`

## Requirements
- R1: After reset every output level, output enable and mux select is 0, so all bidirectional pins are inputs driven low. Every state register reads 0 while the pin inputs are 0.
- R2: Writing to an output-set register drives high each pin whose data bit is 1, from the clock edge that samples the write. Pins whose bit is 0 keep their level.
- R3: Writing to an output-clear register drives low each pin whose data bit is 1. Pins whose bit is 0 keep their level.
- R4: For each direction register, set makes a pin an output (output enable 1) and clear makes it an input (output enable 0). The current enables read back from the matching direction state register.
- R5: The 8-pin and 24-pin ports use pin n at bit n. Their blocks start at byte addresses 0x40 and 0x60, with offsets +0x00 input state, +0x04 output set, +0x08 output clear, +0x0C output state, +0x10 direction set, +0x14 direction clear and +0x18 direction state.
- R6: The 13-pin port uses pin n at bit n. Its registers are 0x10/0x14/0x18 for direction set/clear/state, 0x1C for input state, 0x20/0x24 for output set/clear, and 0x28/0x2C/0x30 for mux set/clear/state. The mux state drives the mux select outputs.
- R7: Bidirectional pin k (0..5) of the mixed port takes its direction from bit 25+k of registers 0x10/0x14. Its level comes from bit 25+k of 0x04/0x08. Its level reads back at bit 25+k of 0x0C, and its direction reads back at bit 25+k of 0x18.
- R8: Address 0x00 returns mixed bidirectional inputs 0..4 at bits 10..14 and input 5 at bit 24. Input-only pin i appears at bit i for i in 0..9, 15..23 and 25..27. Input-only pins 10..14 and 24 are never visible, and bits 28..31 read 0.
- R9: Output-only pins 0..23 are set and cleared by bits 0..23 of 0x04/0x08, and their levels read back at bits 0..23 of 0x0C.
- R10: A change on any pin input is not visible after one clock edge. It is visible in the input state after the second edge.
- R11: Unmapped addresses (including every address from 0x80 up) and unused bits read 0. Writes to read-only or unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pa_in_i | input | 8 | 8-pin port pin inputs |
| pa_out_o | output | 8 | 8-pin port output levels |
| pa_oe_o | output | 8 | 8-pin port output enables |
| pb_in_i | input | 24 | 24-pin port pin inputs |
| pb_out_o | output | 24 | 24-pin port output levels |
| pb_oe_o | output | 24 | 24-pin port output enables |
| pc_in_i | input | 13 | 13-pin port pin inputs |
| pc_out_o | output | 13 | 13-pin port output levels |
| pc_oe_o | output | 13 | 13-pin port output enables |
| pc_mux_o | output | 13 | 13-pin port mux selects |
| xb_in_i | input | 6 | Mixed port bidirectional pin inputs |
| xb_out_o | output | 6 | Mixed port bidirectional output levels |
| xb_oe_o | output | 6 | Mixed port bidirectional output enables |
| xi_in_i | input | 28 | Mixed port input-only pins |
| xo_out_o | output | 24 | Mixed port output-only pins |

## Verification
A wrong bit in a level, direction or mux register shows up on the pin outputs in the cycle after the write that caused it. The same bit also reads back wrong from the state register at once. A decode slip, such as a wrong port base or a shifted mixed-port bit position, either moves a change onto the wrong pin or makes a read return a bit from a neighbouring field. It shows on the first read of that register. A synchronizer with the wrong depth shows as an input-state value that changes one cycle early or late after a pin edge.

// File: rtl/gpio_mp_pkg.sv
`timescale 1ns/1ps
package gpio_mp_pkg;
  localparam int unsigned AW   = 8;
  localparam int unsigned DW   = 32;
  localparam int unsigned PA_W = 8;
  localparam int unsigned PB_W = 24;
  localparam int unsigned PC_W = 13;
  localparam int unsigned XB_W = 6;
  localparam int unsigned XI_W = 28;
  localparam int unsigned XO_W = 24;
  localparam int unsigned XB_LSB = 25;
  localparam int unsigned XB_IN_LO = 10;
  localparam int unsigned XB_IN_HI_BIT = 24;

  // regular port block offsets
  localparam logic [AW-1:0] OFS_IN   = 8'h00;
  localparam logic [AW-1:0] OFS_OSET = 8'h04;
  localparam logic [AW-1:0] OFS_OCLR = 8'h08;
  localparam logic [AW-1:0] OFS_OST  = 8'h0C;
  localparam logic [AW-1:0] OFS_DSET = 8'h10;
  localparam logic [AW-1:0] OFS_DCLR = 8'h14;
  localparam logic [AW-1:0] OFS_DST  = 8'h18;
  localparam logic [AW-1:0] PA_BASE  = 8'h40;
  localparam logic [AW-1:0] PB_BASE  = 8'h60;

  // mixed / 13-pin shared block
  localparam logic [AW-1:0] X_IN   = 8'h00;
  localparam logic [AW-1:0] X_OSET = 8'h04;
  localparam logic [AW-1:0] X_OCLR = 8'h08;
  localparam logic [AW-1:0] X_OST  = 8'h0C;
  localparam logic [AW-1:0] C_DSET = 8'h10;
  localparam logic [AW-1:0] C_DCLR = 8'h14;
  localparam logic [AW-1:0] C_DST  = 8'h18;
  localparam logic [AW-1:0] C_IN   = 8'h1C;
  localparam logic [AW-1:0] C_OSET = 8'h20;
  localparam logic [AW-1:0] C_OCLR = 8'h24;
  localparam logic [AW-1:0] C_MSET = 8'h28;
  localparam logic [AW-1:0] C_MCLR = 8'h2C;
  localparam logic [AW-1:0] C_MST  = 8'h30;
endpackage

// File: rtl/gpio_setclr_reg.sv
`timescale 1ns/1ps
module gpio_setclr_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;  // set wins
  end

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|set_i) && !(|clr_i)) |=> $stable(q_o));
endmodule

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_mp_pkg::*;
#(
  parameter int unsigned    W    = 8,
  parameter logic [AW-1:0]  BASE = 8'h40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [W-1:0]  pin_i,
  output logic [W-1:0]  out_o,
  output logic [W-1:0]  oe_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned PAD = DW - W;

  logic [W-1:0] wd, in_s, oset, oclr, dset, dclr;
  assign wd = wdata_i[W-1:0];

  always_comb begin
    oset = '0; oclr = '0; dset = '0; dclr = '0;
    if (we_i) begin
      if (addr_i == BASE + OFS_OSET) oset = wd;
      if (addr_i == BASE + OFS_OCLR) oclr = wd;
      if (addr_i == BASE + OFS_DSET) dset = wd;
      if (addr_i == BASE + OFS_DCLR) dclr = wd;
    end
  end

  gpio_setclr_reg #(.W(W)) u_out (
    .clk_i, .rst_ni, .set_i(oset), .clr_i(oclr), .q_o(out_o));
  gpio_setclr_reg #(.W(W)) u_dir (
    .clk_i, .rst_ni, .set_i(dset), .clr_i(dclr), .q_o(oe_o));
  gpio_sync #(.W(W)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(in_s));

  always_comb begin
    rdata_o = '0;
    if (addr_i == BASE + OFS_IN)  rdata_o = {{PAD{1'b0}}, in_s};
    if (addr_i == BASE + OFS_OST) rdata_o = {{PAD{1'b0}}, out_o};
    if (addr_i == BASE + OFS_DST) rdata_o = {{PAD{1'b0}}, oe_o};
  end

  if (W < DW) begin : g_unused
    logic unused_wd;
    assign unused_wd = ^wdata_i[DW-1:W];
  end
endmodule

// File: rtl/gpio_multiport.sv
`timescale 1ns/1ps
module gpio_multiport
  import gpio_mp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [PA_W-1:0] pa_in_i,
  output logic [PA_W-1:0] pa_out_o,
  output logic [PA_W-1:0] pa_oe_o,
  input  logic [PB_W-1:0] pb_in_i,
  output logic [PB_W-1:0] pb_out_o,
  output logic [PB_W-1:0] pb_oe_o,
  input  logic [PC_W-1:0] pc_in_i,
  output logic [PC_W-1:0] pc_out_o,
  output logic [PC_W-1:0] pc_oe_o,
  output logic [PC_W-1:0] pc_mux_o,
  input  logic [XB_W-1:0] xb_in_i,
  output logic [XB_W-1:0] xb_out_o,
  output logic [XB_W-1:0] xb_oe_o,
  input  logic [XI_W-1:0] xi_in_i,
  output logic [XO_W-1:0] xo_out_o
);
  localparam int unsigned XI_USED = 22;

  logic [DW-1:0] pa_rd, pb_rd, x_rd;

  gpio_port #(.W(PA_W), .BASE(PA_BASE)) u_pa (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .pin_i(pa_in_i),
    .out_o(pa_out_o), .oe_o(pa_oe_o), .rdata_o(pa_rd));
  gpio_port #(.W(PB_W), .BASE(PB_BASE)) u_pb (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .pin_i(pb_in_i),
    .out_o(pb_out_o), .oe_o(pb_oe_o), .rdata_o(pb_rd));

  // shared 13-pin / mixed block strobes
  logic [PC_W-1:0] c_oset, c_oclr, c_dset, c_dclr, c_mset, c_mclr;
  logic [XB_W-1:0] xb_oset, xb_oclr, xb_dset, xb_dclr;
  logic [XO_W-1:0] xo_set, xo_clr;

  always_comb begin
    c_oset = '0; c_oclr = '0; c_dset = '0; c_dclr = '0; c_mset = '0; c_mclr = '0;
    xb_oset = '0; xb_oclr = '0; xb_dset = '0; xb_dclr = '0;
    xo_set = '0; xo_clr = '0;
    if (we_i) begin
      unique case (addr_i)
        X_OSET: begin
          xo_set  = wdata_i[XO_W-1:0];
          xb_oset = wdata_i[XB_LSB +: XB_W];
        end
        X_OCLR: begin
          xo_clr  = wdata_i[XO_W-1:0];
          xb_oclr = wdata_i[XB_LSB +: XB_W];
        end
        C_DSET: begin
          c_dset  = wdata_i[PC_W-1:0];
          xb_dset = wdata_i[XB_LSB +: XB_W];
        end
        C_DCLR: begin
          c_dclr  = wdata_i[PC_W-1:0];
          xb_dclr = wdata_i[XB_LSB +: XB_W];
        end
        C_OSET: c_oset = wdata_i[PC_W-1:0];
        C_OCLR: c_oclr = wdata_i[PC_W-1:0];
        C_MSET: c_mset = wdata_i[PC_W-1:0];
        C_MCLR: c_mclr = wdata_i[PC_W-1:0];
        default: ;
      endcase
    end
  end

  gpio_setclr_reg #(.W(PC_W)) u_pc_out (
    .clk_i, .rst_ni, .set_i(c_oset), .clr_i(c_oclr), .q_o(pc_out_o));
  gpio_setclr_reg #(.W(PC_W)) u_pc_dir (
    .clk_i, .rst_ni, .set_i(c_dset), .clr_i(c_dclr), .q_o(pc_oe_o));
  gpio_setclr_reg #(.W(PC_W)) u_pc_mux (
    .clk_i, .rst_ni, .set_i(c_mset), .clr_i(c_mclr), .q_o(pc_mux_o));
  gpio_setclr_reg #(.W(XB_W)) u_xb_out (
    .clk_i, .rst_ni, .set_i(xb_oset), .clr_i(xb_oclr), .q_o(xb_out_o));
  gpio_setclr_reg #(.W(XB_W)) u_xb_dir (
    .clk_i, .rst_ni, .set_i(xb_dset), .clr_i(xb_dclr), .q_o(xb_oe_o));
  gpio_setclr_reg #(.W(XO_W)) u_xo_out (
    .clk_i, .rst_ni, .set_i(xo_set), .clr_i(xo_clr), .q_o(xo_out_o));

  // input synchronizers; input-only bits 10..14 and 24 have no read position
  logic [PC_W-1:0]    pc_s;
  logic [XB_W-1:0]    xb_s;
  logic [XI_USED-1:0] xi_used, xi_s;
  logic               unused_xi;
  assign xi_used   = {xi_in_i[27:25], xi_in_i[23:15], xi_in_i[9:0]};
  assign unused_xi = ^{xi_in_i[14:10], xi_in_i[24]};

  gpio_sync #(.W(PC_W))    u_pc_sync (.clk_i, .rst_ni, .d_i(pc_in_i), .q_o(pc_s));
  gpio_sync #(.W(XB_W))    u_xb_sync (.clk_i, .rst_ni, .d_i(xb_in_i), .q_o(xb_s));
  gpio_sync #(.W(XI_USED)) u_xi_sync (.clk_i, .rst_ni, .d_i(xi_used), .q_o(xi_s));

  always_comb begin
    x_rd = '0;
    unique case (addr_i)
      X_IN:  x_rd = {4'b0, xi_s[21:19], xb_s[5], xi_s[18:10], xb_s[4:0], xi_s[9:0]};
      X_OST: x_rd = {1'b0, xb_out_o, 1'b0, xo_out_o};
      C_DST: x_rd = {1'b0, xb_oe_o, 12'b0, pc_oe_o};
      C_IN:  x_rd = {{(DW-PC_W){1'b0}}, pc_s};
      C_MST: x_rd = {{(DW-PC_W){1'b0}}, pc_mux_o};
      default: ;
    endcase
  end

  assign rdata_o = pa_rd | pb_rd | x_rd;

  p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= 8'h80) |-> (rdata_o == '0));
  p_xo_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == X_OSET) |=>
      ((xo_out_o & $past(wdata_i[XO_W-1:0])) == $past(wdata_i[XO_W-1:0])));
  p_xb_dir_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == C_DSET) |=>
      ((xb_oe_o & $past(wdata_i[XB_LSB +: XB_W])) == $past(wdata_i[XB_LSB +: XB_W])));
endmodule

// File: tb/gpio_multiport_tb.sv
`timescale 1ns/1ps
module gpio_multiport_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pa_in = '0, pa_out, pa_oe;
  logic [23:0] pb_in = '0, pb_out, pb_oe;
  logic [12:0] pc_in = '0, pc_out, pc_oe, pc_mux;
  logic [5:0]  xb_in = '0, xb_out, xb_oe;
  logic [27:0] xi_in = '0;
  logic [23:0] xo_out;

  gpio_multiport u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pa_in_i(pa_in), .pa_out_o(pa_out), .pa_oe_o(pa_oe),
    .pb_in_i(pb_in), .pb_out_o(pb_out), .pb_oe_o(pb_oe),
    .pc_in_i(pc_in), .pc_out_o(pc_out), .pc_oe_o(pc_oe), .pc_mux_o(pc_mux),
    .xb_in_i(xb_in), .xb_out_o(xb_out), .xb_oe_o(xb_oe),
    .xi_in_i(xi_in), .xo_out_o(xo_out));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0]  m_pa_out = '0, m_pa_dir = '0;
  logic [23:0] m_pb_out = '0, m_pb_dir = '0;
  logic [12:0] m_pc_out = '0, m_pc_dir = '0, m_mux = '0;
  logic [5:0]  m_xb_out = '0, m_xb_dir = '0;
  logic [23:0] m_xo = '0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h04: begin m_xo = m_xo | d[23:0]; m_xb_out = m_xb_out | d[30:25]; end
      8'h08: begin m_xo = m_xo & ~d[23:0]; m_xb_out = m_xb_out & ~d[30:25]; end
      8'h10: begin m_pc_dir = m_pc_dir | d[12:0]; m_xb_dir = m_xb_dir | d[30:25]; end
      8'h14: begin m_pc_dir = m_pc_dir & ~d[12:0]; m_xb_dir = m_xb_dir & ~d[30:25]; end
      8'h20: m_pc_out = m_pc_out | d[12:0];
      8'h24: m_pc_out = m_pc_out & ~d[12:0];
      8'h28: m_mux = m_mux | d[12:0];
      8'h2C: m_mux = m_mux & ~d[12:0];
      8'h44: m_pa_out = m_pa_out | d[7:0];
      8'h48: m_pa_out = m_pa_out & ~d[7:0];
      8'h50: m_pa_dir = m_pa_dir | d[7:0];
      8'h54: m_pa_dir = m_pa_dir & ~d[7:0];
      8'h64: m_pb_out = m_pb_out | d[23:0];
      8'h68: m_pb_out = m_pb_out & ~d[23:0];
      8'h70: m_pb_dir = m_pb_dir | d[23:0];
      8'h74: m_pb_dir = m_pb_dir & ~d[23:0];
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] r = '0;
    case (a)
      8'h00: begin
        for (int i = 0; i < 28; i++)
          if (!(i >= 10 && i <= 14) && i != 24) r[i] = xi_in[i];
        for (int k = 0; k < 5; k++) r[10+k] = xb_in[k];
        r[24] = xb_in[5];
      end
      8'h0C: begin r[23:0] = m_xo; r[30:25] = m_xb_out; end
      8'h18: begin r[12:0] = m_pc_dir; r[30:25] = m_xb_dir; end
      8'h1C: r[12:0] = pc_in;
      8'h30: r[12:0] = m_mux;
      8'h40: r[7:0] = pa_in;
      8'h4C: r[7:0] = m_pa_out;
      8'h58: r[7:0] = m_pa_dir;
      8'h60: r[23:0] = pb_in;
      8'h6C: r[23:0] = m_pb_out;
      8'h78: r[23:0] = m_pb_dir;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic set_inputs(input logic [7:0] a8, input logic [23:0] b24,
                            input logic [12:0] c13, input logic [5:0] x6,
                            input logic [27:0] i28);
    @(negedge clk);
    pa_in = a8; pb_in = b24; pc_in = c13; xb_in = x6; xi_in = i28;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_pins(input string tag);
    chk({tag, " pa_out R2 R3 R5"}, {24'b0, pa_out}, {24'b0, m_pa_out});
    chk({tag, " pa_oe R4"}, {24'b0, pa_oe}, {24'b0, m_pa_dir});
    chk({tag, " pb_out R2 R3 R5"}, {8'b0, pb_out}, {8'b0, m_pb_out});
    chk({tag, " pb_oe R4"}, {8'b0, pb_oe}, {8'b0, m_pb_dir});
    chk({tag, " pc_out R6"}, {19'b0, pc_out}, {19'b0, m_pc_out});
    chk({tag, " pc_oe R6"}, {19'b0, pc_oe}, {19'b0, m_pc_dir});
    chk({tag, " pc_mux R6"}, {19'b0, pc_mux}, {19'b0, m_mux});
    chk({tag, " xb_out R7"}, {26'b0, xb_out}, {26'b0, m_xb_out});
    chk({tag, " xb_oe R7"}, {26'b0, xb_oe}, {26'b0, m_xb_dir});
    chk({tag, " xo_out R9"}, {8'b0, xo_out}, {8'b0, m_xo});
  endtask

  localparam int NRD = 11;
  logic [7:0] rd_addrs [NRD] = '{8'h00, 8'h0C, 8'h18, 8'h1C, 8'h30, 8'h40,
                                 8'h4C, 8'h58, 8'h60, 8'h6C, 8'h78};
  localparam int NWR = 20;
  logic [7:0] wr_addrs [NWR] = '{8'h04, 8'h08, 8'h10, 8'h14, 8'h20, 8'h24,
                                 8'h28, 8'h2C, 8'h44, 8'h48, 8'h50, 8'h54,
                                 8'h64, 8'h68, 8'h70, 8'h74, 8'h00, 8'h18,
                                 8'h84, 8'h34};

  task automatic check_reads(input string tag);
    logic [31:0] d;
    for (int i = 0; i < NRD; i++) begin
      do_read(rd_addrs[i], d);
      chk($sformatf("%s read %h R5 R6 R7 R8 R9", tag, rd_addrs[i]), d, exp_read(rd_addrs[i]));
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_pins("R1 reset");
    check_reads("R1 reset");

    // R2 / R3 directed on 8-pin port
    do_write(8'h44, 32'h0000_00A5);
    chk("R2 pa set", {24'b0, pa_out}, 32'hA5);
    do_write(8'h44, 32'h0000_0002);
    chk("R2 pa set keeps zeros", {24'b0, pa_out}, 32'hA7);
    do_write(8'h48, 32'h0000_0081);
    chk("R3 pa clear", {24'b0, pa_out}, 32'h26);
    do_read(8'h4C, d);
    chk("R5 pa out state", d, 32'h26);

    // R4 direction on 24-pin port
    do_write(8'h70, 32'h0080_0001);
    chk("R4 pb oe set", {8'b0, pb_oe}, 32'h0080_0001);
    do_write(8'h74, 32'h0000_0001);
    do_read(8'h78, d);
    chk("R4 pb dir state", d, 32'h0080_0000);

    // R7 mixed bidirectional share 13-pin direction registers
    do_write(8'h10, 32'h4200_1001);
    chk("R7 xb oe", {26'b0, xb_oe}, 32'h21);
    chk("R6 pc oe", {19'b0, pc_oe}, 32'h1001);
    do_read(8'h18, d);
    chk("R7 dir state", d, 32'h4200_1001);
    do_write(8'h04, 32'h7E80_0001);
    chk("R7 xb out", {26'b0, xb_out}, 32'h3F);
    chk("R9 xo out", {8'b0, xo_out}, 32'h80_0001);
    do_read(8'h0C, d);
    chk("R9 out state", d, 32'h7E80_0001);
    do_write(8'h08, 32'h0200_0001);
    do_read(8'h0C, d);
    chk("R9 out state after clear", d, 32'h7C80_0000);

    // R6 mux
    do_write(8'h28, 32'h0000_1FFF);
    do_write(8'h2C, 32'h0000_0F0F);
    chk("R6 mux", {19'b0, pc_mux}, 32'h10F0);

    // R8 input mapping
    set_inputs('0, '0, '0, 6'h3F, '0);
    do_read(8'h00, d);
    chk("R8 xb inputs only", d, 32'h0100_7C00);
    set_inputs('0, '0, '0, 6'h00, 28'hFFF_FFFF);
    do_read(8'h00, d);
    chk("R8 input-only pins", d, 32'h0EFF_83FF);

    // R10 synchronizer depth
    set_inputs('0, '0, '0, '0, '0);
    @(negedge clk);
    pa_in = 8'h5A;
    do_read(8'h40, d);
    chk("R10 not after one edge", d, 32'h0);
    do_read(8'h40, d);
    chk("R10 after two edges", d, 32'h5A);

    // R11 unmapped reads and writes to read-only addresses
    do_read(8'h34, d);  chk("R11 read 0x34", d, 32'h0);
    do_read(8'h80, d);  chk("R11 read 0x80", d, 32'h0);
    do_read(8'hFC, d);  chk("R11 read 0xFC", d, 32'h0);
    do_write(8'h00, 32'hFFFF_FFFF);
    do_write(8'h4C, 32'hFFFF_FFFF);
    do_write(8'h90, 32'hFFFF_FFFF);
    check_pins("R11 ro write");
    check_reads("R11 ro write");

    // constrained random
    for (int it = 0; it < 300; it++) begin
      logic [7:0] a;
      a = wr_addrs[$urandom % NWR];
      do_write(a, $urandom);
      if (it % 10 == 0) begin
        set_inputs(8'($urandom), 24'($urandom), 13'($urandom), 6'($urandom), 28'($urandom));
        check_reads("rand");
      end
      check_pins("rand");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule